// File: doc/BRIEF.md
# Mode-Selectable Serial Word Receiver

This block assembles a serial bit stream into either an 8-bit or a 16-bit parallel word. A mode input, captured when a frame begins, picks the length. The block has two byte-wide shift registers. In the wide mode the serial input enters the upper register, and the upper register's low bit spills into the lower register. In the narrow mode the serial input goes straight into the lower register. The first bit received ends up as bit 0 of the word.

The shift clock arrives as a data input, synchronous to the system clock. The block detects its edges and samples the serial input on each falling edge. A one-cycle start pulse arms a pending request, and the next rising edge of the shift clock consumes it. Once the last bit of the frame has been sampled, a ready flag rises. A read strobe then places the word on the parallel bus and clears the flag.

Top module: `dual_width_rx`

## Requirements
- R1: While and after reset, `ready_o` is 0 and `data_o` is all zeros.
- R2: In 16-bit mode (`mode16_i` = 1 at frame start), the first bit received lands in bit 0 and the sixteenth lands in bit 15. The stream 1010001100000101 in time order reads back as 16'hA0C5.
- R3: In 8-bit mode (`mode16_i` = 0 at frame start), eight bits are assembled LSB first into `data_o[7:0]`, and `data_o[15:8]` reads as zero.
- R4: `sdi_i` is sampled only in the system-clock cycle in which `sck_i` is first seen low after being high. Changes of `sdi_i` at any other time have no effect on the word.
- R5: A start pulse is held pending until the next rising edge of `sck_i`, which clears it and opens the frame. Falling edges of `sck_i` outside an open frame capture nothing.
- R6: `ready_o` is 0 until the final falling edge of the frame (the 16th in 16-bit mode, the 8th in 8-bit mode). It goes to 1 one system-clock cycle after that edge is seen.
- R7: `data_o` is all zeros whenever `rd_i` is 0. A cycle with `rd_i` = 1 clears `ready_o` on the next clock edge.
- R8: The mode is fixed for the whole frame. A change of `mode16_i` after the frame opens changes neither the frame length nor the bus layout.
- R9: A start pulse that arrives while a frame is open is ignored. No second frame follows.
- R10: Opening a new frame clears a `ready_o` that has not been read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Shift clock, synchronous to clk_i |
| sdi_i | input | 1 | Serial data in |
| start_i | input | 1 | Receive-start pulse |
| mode16_i | input | 1 | 1 = 16-bit frame, 0 = 8-bit frame |
| rd_i | input | 1 | Read strobe, drives the bus while high |
| data_o | output | 16 | Parallel word, zero when not read |
| ready_o | output | 1 | Frame complete, not yet read |

## Verification
The hardest case to reach is a frame that is disturbed while it is open: the mode flips and a second start arrives partway through a 16-bit frame. Reaching it needs control at single-bit granularity inside the frame, so the frame task takes a bit index at which to flip `mode16_i` and another at which to pulse `start_i`. After the frame finishes, extra shift-clock pulses are sent. If `ready_o` stays low and the read word is unchanged, no hidden second frame was armed. Every frame also toggles `sdi_i` during the low and high phases of the shift clock, so that sampling at the wrong moment would corrupt the word.

// File: rtl/rx_sio_pkg.sv
package rx_sio_pkg;
  typedef enum logic {
    MODE_BYTE = 1'b0,
    MODE_HALF = 1'b1
  } rx_mode_e;
endpackage

// File: rtl/rx_sck_edge.sv
module rx_sck_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  output logic rise_o,
  output logic fall_o
);
  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_i;
  end

  assign rise_o = sck_i & ~sck_q;
  assign fall_o = ~sck_i & sck_q;
endmodule

// File: rtl/rx_byte_sreg.sv
module rx_byte_sreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         sin_i,
  output logic [W-1:0] q_o,
  output logic         sout_o
);
  logic [W-1:0] q_q;

  // right shift: new bit enters MSB, oldest leaves at bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (en_i) q_q <= {sin_i, q_q[W-1:1]};
  end

  assign q_o    = q_q;
  assign sout_o = q_q[0];
endmodule

// File: rtl/rx_frame_ctl.sv
module rx_frame_ctl
  import rx_sio_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int CNT_W  = $clog2(WORD_W)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     rise_i,
  input  logic     fall_i,
  input  logic     start_i,
  input  logic     mode16_i,
  input  logic     rd_i,
  output logic     shift_o,
  output rx_mode_e mode_o,
  output logic     pend_o,
  output logic     active_o,
  output logic     ready_o
);
  logic             pend_q, active_q, ready_q;
  rx_mode_e         mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_bit;
  logic             open_frame;

  assign open_frame = rise_i & pend_q;
  assign shift_o    = fall_i & active_q;
  assign last_bit   = (mode_q == MODE_HALF) ? (cnt_q == CNT_W'(WORD_W - 1))
                                            : (cnt_q == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      active_q <= 1'b0;
      mode_q   <= MODE_BYTE;
      cnt_q    <= '0;
    end else if (open_frame) begin
      pend_q   <= 1'b0;
      active_q <= 1'b1;
      mode_q   <= rx_mode_e'(mode16_i);
      cnt_q    <= '0;
    end else begin
      if (start_i && !active_q) pend_q <= 1'b1;
      if (shift_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_bit) active_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ready_q <= 1'b0;
    else if (open_frame)          ready_q <= 1'b0;
    else if (shift_o && last_bit) ready_q <= 1'b1;
    else if (rd_i)                ready_q <= 1'b0;
  end

  assign mode_o   = mode_q;
  assign pend_o   = pend_q;
  assign active_o = active_q;
  assign ready_o  = ready_q;
endmodule

// File: rtl/dual_width_rx.sv
module dual_width_rx
  import rx_sio_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              start_i,
  input  logic              mode16_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] data_o,
  output logic              ready_o
);
  logic     sck_rise, sck_fall, shift;
  logic     pend_q, active_q;
  rx_mode_e mode_q;

  logic [1:0]        lane_en, lane_sin, lane_sout;
  logic [BYTE_W-1:0] lane_q [2];

  rx_sck_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .rise_o (sck_rise),
    .fall_o (sck_fall)
  );

  rx_frame_ctl #(.BYTE_W(BYTE_W)) u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (sck_rise),
    .fall_i   (sck_fall),
    .start_i  (start_i),
    .mode16_i (mode16_i),
    .rd_i     (rd_i),
    .shift_o  (shift),
    .mode_o   (mode_q),
    .pend_o   (pend_q),
    .active_o (active_q),
    .ready_o  (ready_o)
  );

  // lane 1 = upper byte, lane 0 = lower byte; mode gates the chain
  assign lane_sin[1] = sdi_i;
  assign lane_en[1]  = shift & (mode_q == MODE_HALF);
  assign lane_sin[0] = (mode_q == MODE_HALF) ? lane_sout[1] : sdi_i;
  assign lane_en[0]  = shift;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    rx_byte_sreg #(.W(BYTE_W)) u_sreg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (lane_en[g]),
      .sin_i  (lane_sin[g]),
      .q_o    (lane_q[g]),
      .sout_o (lane_sout[g])
    );
  end

  always_comb begin
    data_o = '0;
    if (rd_i) begin
      data_o[BYTE_W-1:0] = lane_q[0];
      if (mode_q == MODE_HALF) data_o[WORD_W-1:BYTE_W] = lane_q[1];
    end
  end
endmodule

// File: rtl/dual_width_rx_chk.sv
module dual_width_rx_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sck_i,
  input logic              rd_i,
  input logic [WORD_W-1:0] data_o,
  input logic              ready_o,
  input logic              pend_i,
  input logic              active_i,
  input logic              mode16_q_i
);
  // R1
  rst_idle_chk: assert property (@(posedge clk_i) !rst_ni |-> !ready_o);

  // R7
  bus_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> data_o == '0);

  // R3
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !mode16_q_i) |-> data_o[WORD_W-1:WORD_W/2] == '0);

  // R5
  start_consume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && $rose(sck_i)) |=> (!pend_i && active_i));

  // R6
  ready_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(sck_i, 2) && !$past(sck_i)));

  // R7
  ready_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> ($past(rd_i) || $past(pend_i)));

  // R9
  no_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !pend_i) |=> !pend_i);

  // R8
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && $past(active_i)) |-> $stable(mode16_q_i));
endmodule

bind dual_width_rx dual_width_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sck_i      (sck_i),
  .rd_i       (rd_i),
  .data_o     (data_o),
  .ready_o    (ready_o),
  .pend_i     (pend_q),
  .active_i   (active_q),
  .mode16_q_i (mode_q == rx_sio_pkg::MODE_HALF)
);

// File: tb/sim_dual_width_rx.sv
module sim_dual_width_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, sdi = 1'b0, start = 1'b0, mode16 = 1'b0, rd = 1'b0;
  logic [15:0] data;
  logic        ready;
  int          n_chk = 0, n_err = 0, cyc = 0;

  always #10 clk = ~clk;

  dual_width_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .sdi_i(sdi), .start_i(start),
    .mode16_i(mode16), .rd_i(rd), .data_o(data), .ready_o(ready)
  );

  // {mode16, stream}; bit i of stream is sent i-th
  localparam logic [16:0] VEC [6] = '{
    {1'b1, 16'hA0C5}, {1'b0, 16'h0034}, {1'b1, 16'hFFFF},
    {1'b0, 16'h00A5}, {1'b1, 16'h8001}, {1'b0, 16'h00FF}
  };

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame; flip_at toggles mode16 and restart_at pulses start at that bit (-1 = never)
  task automatic send_frame(input bit m16, input logic [15:0] s, input int flip_at, input int restart_at);
    int nb = m16 ? 16 : 8;
    mode16 = m16;
    start = 1'b1; tick(1); start = 1'b0;
    tick(2);
    sck = 1'b1; tick(3);
    chk(ready == 1'b0, "R10 open clears ready", {15'd0, ready}, 16'd0);
    for (int i = 0; i < nb; i++) begin
      if (i == flip_at) mode16 = ~mode16;
      if (i == restart_at) begin start = 1'b1; tick(1); start = 1'b0; end
      if (i == nb - 1) chk(ready == 1'b0, "R6 ready before last fall", {15'd0, ready}, 16'd0);
      sdi = s[i]; sck = 1'b0;
      tick(1);
      if (i == nb - 1) chk(ready == 1'b1, "R6 ready after last fall", {15'd0, ready}, 16'd1);
      sdi = ~s[i];  // R4 noise in low phase
      tick(2);
      if (i != nb - 1) begin sck = 1'b1; tick(3); end
    end
    mode16 = m16;
  endtask

  task automatic read_word(input string req, input logic [15:0] exp);
    chk(data == 16'h0, "R7 bus idle without rd", data, 16'h0);
    rd = 1'b1; #1;
    chk(data == exp, req, data, exp);
    tick(1); rd = 1'b0;
    tick(1);
    chk(ready == 1'b0, "R7 rd clears ready", {15'd0, ready}, 16'd0);
  endtask

  initial begin
    tick(3);
    chk(ready == 1'b0 && data == 16'h0, "R1 reset state", {ready, data[14:0]}, 16'd0);
    rst_n = 1'b1;
    tick(2);
    chk(ready == 1'b0, "R1 after reset", {15'd0, ready}, 16'd0);

    // R5: shift clocking with no start captures nothing
    sdi = 1'b1;
    for (int k = 0; k < 20; k++) begin sck = 1'b1; tick(2); sck = 1'b0; tick(2); end
    chk(ready == 1'b0, "R5 no frame without start", {15'd0, ready}, 16'd0);

    for (int v = 0; v < 6; v++) begin
      logic [15:0] exp;
      exp = VEC[v][16] ? VEC[v][15:0] : {8'h00, VEC[v][7:0]};
      send_frame(VEC[v][16], VEC[v][15:0], -1, -1);
      tick(2);
      read_word(VEC[v][16] ? "R2 wide word" : "R3 narrow word", exp);
    end

    // R10: unread ready cleared by next frame opening (checked inside send_frame)
    send_frame(1'b0, 16'h005A, -1, -1);
    tick(2);
    send_frame(1'b0, 16'h00C3, -1, -1);
    tick(2);
    read_word("R10 second frame word", 16'h00C3);

    // R8: mode flip mid-frame keeps 16-bit length and layout
    send_frame(1'b1, 16'h5A3C, 3, -1);
    tick(2);
    read_word("R8 mode held", 16'h5A3C);

    // R9: start inside open frame ignored
    send_frame(1'b1, 16'h1234, -1, 6);
    tick(2);
    read_word("R9 word intact", 16'h1234);
    sdi = 1'b0;
    for (int k = 0; k < 10; k++) begin sck = 1'b1; tick(3); sck = 1'b0; tick(3); end
    chk(ready == 1'b0, "R9 no second frame", {15'd0, ready}, 16'd0);
    rd = 1'b1; #1;
    chk(data == 16'h1234, "R9 word unchanged", data, 16'h1234);
    tick(1); rd = 1'b0;

    // R3: narrow frame after wide frame; upper byte reads zero
    send_frame(1'b0, 16'hFF81, -1, -1);
    tick(2);
    read_word("R3 upper zero", 16'h0081);

    tick(4);
    report();
  end
endmodule